// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital side of an 8-bit successive-approximation converter on a small processor bus. A free-running prescaler divides the system clock by six to make the converter clock. Each conversion uses 48 converter clocks, which is 288 system clocks. The comparator input, multiplexer and reference are external. The block drives a trial code to them and reads back one comparator decision bit.

Software starts a conversion by writing the control register with the enable bit set. The block waits for the next prescaler boundary and then decides the result bits one at a time, most significant first, using six converter clocks per bit. At the end it loads the result register, raises the end-of-conversion flag and latches a level interrupt. Any later write to the control register clears that interrupt. Clearing the enable bit abandons a conversion that is running. The external stop input freezes the converter clock for as long as it is held. The comparator power-enable output is low whenever the block is disabled or stopped.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The end-of-conversion flag rises between 289 and 294 system clocks after the clock edge that samples a start write. This is 288 clocks of conversion plus 1 to 6 clocks of prescaler alignment.
- R2: The converter decides the result from bit 7 down to bit 0. When a bit is tried, the trial code holds the bits already decided, a 1 in the bit under test and 0 below it. A comparator input of 1 keeps that bit and 0 clears it. With a steady analog level V, the result is V.
- R3: The result output changes only on the edge where the end-of-conversion flag rises. Between conversions and during a conversion it keeps its previous value.
- R4: A bus write of a value with bit 5 = 1 to address 0x10 starts a conversion. It also clears the end-of-conversion flag on the same edge.
- R5: The comparator power-enable output is registered. It equals the enable bit (bit 5 of the last write to 0x10) AND NOT the stop input, and it is 0 on the cycle after any cycle in which stop is high.
- R6: While stop is high, the prescaler and the conversion are frozen and the trial code does not change. A stop held for N cycles during a conversion delays the end-of-conversion flag by exactly N cycles and leaves the result correct.
- R7: A write to 0x10 with bit 5 = 0 abandons any pending or running conversion. No end-of-conversion flag follows, and the result keeps its old value.
- R8: The interrupt output goes high one cycle after a rising edge of the end-of-conversion flag and stays high.
- R9: Any write to address 0x10 clears the interrupt one cycle after that write. Writes to other addresses leave the interrupt, the flag and the enable state unchanged.
- R10: If a control write falls on the same cycle as the interrupt set, the set wins and the interrupt stays high.
- R11: Synchronous reset clears the interrupt, the flag, the result, the trial code and the power-enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus write address |
| bus_wdata | input | 8 | Bus write data |
| stop_in | input | 1 | Global stop; freezes the converter clock |
| cmp_in | input | 1 | Comparator decision (1: input at or above the trial code) |
| trial_code_o | output | 8 | Trial code sent to the comparator reference |
| cmp_pwr_en_o | output | 1 | Comparator power enable |
| result_o | output | 8 | Last completed conversion result |
| eoc_o | output | 1 | End-of-conversion flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle. The interrupt rises only after an end-of-conversion edge. It drops only after a control write and holds otherwise. Stop forces power-enable low and freezes the trial code. The result changes only with the flag edge, and a start clears the flag. Only the bench scenarios can show the numeric behaviour. This includes the 289 to 294 cycle latency window, the binary search reaching the analog level for several codes, the exact delay added by a stop, and the abandon path. It also includes the set-over-clear priority on a coinciding write and the fact that writes to other addresses are ignored.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned CTRL_ADDR_DEF = 8'h10;
  localparam int unsigned SC_BIT_DEF    = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_CONV = 2'd2
  } seq_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int unsigned DIV = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic tick
);
  localparam int unsigned CW = sar_pkg::cnt_width(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (run_en) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // one converter-clock strobe per DIV system clocks while running
  assign tick = run_en && (cnt_q == LAST);
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned RES_W = 8,
  parameter int unsigned CPB   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_o
);
  import sar_pkg::*;

  localparam int unsigned BW = cnt_width(RES_W);
  localparam int unsigned PW = cnt_width(CPB);
  localparam logic [BW-1:0] TOP_BIT = BW'(RES_W - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(CPB - 1);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  seq_state_t       st_q;
  logic [BW-1:0]    bidx_q;
  logic [PW-1:0]    ph_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] res_q;
  logic             eoc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      bidx_q <= '0;
      ph_q   <= '0;
      code_q <= '0;
      res_q  <= '0;
      eoc_q  <= 1'b0;
    end else if (start) begin
      st_q   <= SEQ_WAIT;
      code_q <= '0;
      eoc_q  <= 1'b0;
    end else if (abort) begin
      st_q <= SEQ_IDLE;
    end else if (tick) begin
      case (st_q)
        SEQ_WAIT: begin
          st_q   <= SEQ_CONV;
          bidx_q <= TOP_BIT;
          ph_q   <= '0;
          code_q <= MSB_ONE;
        end
        SEQ_CONV: begin
          if (ph_q == PH_LAST) begin
            ph_q           <= '0;
            code_q[bidx_q] <= cmp_in;
            if (bidx_q == '0) begin
              st_q  <= SEQ_IDLE;
              eoc_q <= 1'b1;
              res_q <= {code_q[RES_W-1:1], cmp_in};
            end else begin
              bidx_q                <= bidx_q - 1'b1;
              code_q[bidx_q - 1'b1] <= 1'b1;
            end
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign trial_o  = code_q;
  assign result_o = res_q;
  assign eoc_o    = eoc_q;
endmodule

// File: rtl/sar_irq_latch.sv
module sar_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic eoc,
  input  logic clr,
  output logic irq
);
  logic eoc_d;
  logic irq_q;
  logic set_w;

  assign set_w = eoc && !eoc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_d <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      eoc_d <= eoc;
      if (set_w)    irq_q <= 1'b1;
      else if (clr) irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned RES_W     = 8,
  parameter int unsigned DIV       = 6,
  parameter int unsigned CPB       = 6,
  parameter int unsigned CTRL_ADDR = sar_pkg::CTRL_ADDR_DEF,
  parameter int unsigned SC_BIT    = sar_pkg::SC_BIT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             stop_in,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial_code_o,
  output logic             cmp_pwr_en_o,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_o,
  output logic             irq_o
);
  localparam logic [AW-1:0] CA = AW'(CTRL_ADDR);

  logic ctrl_wr, start_w, abort_w;
  logic sc_q, sc_nxt, pwr_q, run_en, tick_w;

  assign ctrl_wr = bus_wr && (bus_addr == CA);
  assign start_w = ctrl_wr && bus_wdata[SC_BIT];
  assign abort_w = ctrl_wr && !bus_wdata[SC_BIT];
  assign sc_nxt  = ctrl_wr ? bus_wdata[SC_BIT] : sc_q;
  assign run_en  = sc_q && !stop_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_q  <= 1'b0;
      pwr_q <= 1'b0;
    end else begin
      sc_q  <= sc_nxt;
      pwr_q <= sc_nxt && !stop_in;
    end
  end

  assign cmp_pwr_en_o = pwr_q;

  sar_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run_en (run_en),
    .tick   (tick_w)
  );

  sar_engine #(.RES_W(RES_W), .CPB(CPB)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (start_w),
    .abort    (abort_w),
    .tick     (tick_w),
    .cmp_in   (cmp_in),
    .trial_o  (trial_code_o),
    .result_o (result_o),
    .eoc_o    (eoc_o)
  );

  sar_irq_latch u_irq (
    .clk (clk),
    .rst (rst),
    .eoc (eoc_o),
    .clr (ctrl_wr),
    .irq (irq_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 8,
  parameter int unsigned RES_W     = 8,
  parameter int unsigned CTRL_ADDR = 8'h10,
  parameter int unsigned SC_BIT    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             stop_in,
  input logic [RES_W-1:0] trial_code_o,
  input logic             cmp_pwr_en_o,
  input logic [RES_W-1:0] result_o,
  input logic             eoc_o,
  input logic             irq_o
);
  logic cw;
  assign cw = bus_wr && (bus_addr == AW'(CTRL_ADDR));

  // R8
  irq_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(eoc_o) && !$past(eoc_o, 2)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !cw) |=> irq_o);

  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> $past(cw));

  // R5
  pwr_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_in |=> !cmp_pwr_en_o);

  // R3
  result_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> $rose(eoc_o));

  // R4
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cw && bus_wdata[SC_BIT]) |=> !eoc_o);

  // R6
  stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_in && !cw) |=> $stable(trial_code_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .AW(AW), .DW(DW), .RES_W(RES_W), .CTRL_ADDR(CTRL_ADDR), .SC_BIT(SC_BIT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .stop_in      (stop_in),
  .trial_code_o (trial_code_o),
  .cmp_pwr_en_o (cmp_pwr_en_o),
  .result_o     (result_o),
  .eoc_o        (eoc_o),
  .irq_o        (irq_o)
);

// File: tb/sar_conv_ctrl_tb.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb;
  localparam logic [7:0] CTRL = 8'h10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       stop_in = 1'b0;
  logic       cmp_in;
  logic [7:0] trial_code_o, result_o;
  logic       cmp_pwr_en_o, eoc_o, irq_o;
  logic [7:0] vin = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  // comparator model: 1 when the analog level is at or above the trial code
  assign cmp_in = (vin >= trial_code_o);

  sar_conv_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .stop_in(stop_in), .cmp_in(cmp_in),
    .trial_code_o(trial_code_o), .cmp_pwr_en_o(cmp_pwr_en_o),
    .result_o(result_o), .eoc_o(eoc_o), .irq_o(irq_o)
  );

  // {analog level, expected result}
  localparam logic [15:0] VEC [8] = '{
    16'h0000, 16'hFFFF, 16'h8080, 16'h7F7F,
    16'h5555, 16'hAAAA, 16'h0101, 16'hC3C3
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // called at a negedge; the write is sampled at the next posedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic run_conv(input int stop_at, input int stop_len,
                          input logic [7:0] prev, output int n);
    logic [7:0] held = '0;
    n = 0;
    while (n < 400) begin
      if (stop_at > 0 && n == stop_at) stop_in = 1'b1;
      if (stop_at > 0 && n == stop_at + stop_len) begin
        chk("R6 trial frozen", trial_code_o, held);
        stop_in = 1'b0;
      end
      @(negedge clk);
      n++;
      if (stop_at > 0 && n == stop_at + 1) begin
        held = trial_code_o;
        chk("R5 pwr low under stop", cmp_pwr_en_o, 0);
      end
      if (n == 100) chk("R3 result held mid-conversion", result_o, prev);
      if (eoc_o) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 eoc", eoc_o, 0);
    chk("R11 irq", irq_o, 0);
    chk("R11 pwr", cmp_pwr_en_o, 0);
    chk("R11 result", result_o, 0);
    chk("R11 trial", trial_code_o, 0);

    prev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      vin = VEC[i][15:8];
      wr(CTRL, 8'h20);
      chk("R4 eoc cleared by start", eoc_o, 0);
      chk("R5 pwr on", cmp_pwr_en_o, 1);
      run_conv(0, 0, prev, n);
      chk_rng("R1 latency", n, 289, 294);
      chk("R2 result", result_o, VEC[i][7:0]);
      chk("R8 irq not yet", irq_o, 0);
      @(negedge clk);
      chk("R8 irq set", irq_o, 1);
      repeat (5) @(negedge clk);
      chk("R8 irq level held", irq_o, 1);
      wr(CTRL, 8'h00);
      chk("R9 irq cleared", irq_o, 0);
      prev = VEC[i][7:0];
    end

    // R6 stop during conversion, then R10 coinciding write
    vin = 8'h3C;
    wr(CTRL, 8'h20);
    run_conv(120, 20, prev, n);
    chk_rng("R6 latency with stop", n, 309, 314);
    chk("R6 result after stop", result_o, 8'h3C);
    wr(CTRL, 8'h00);
    chk("R10 set beats clear", irq_o, 1);

    // R9 other address ignored
    wr(8'h11, 8'h20);
    chk("R9 other addr irq", irq_o, 1);
    chk("R9 other addr eoc", eoc_o, 1);
    chk("R9 other addr pwr", cmp_pwr_en_o, 0);
    wr(CTRL, 8'h00);
    chk("R9 irq cleared", irq_o, 0);

    // R7 abandon
    vin = 8'h99;
    wr(CTRL, 8'h20);
    chk("R4 eoc cleared", eoc_o, 0);
    repeat (60) @(negedge clk);
    wr(CTRL, 8'h00);
    chk("R5 pwr off", cmp_pwr_en_o, 0);
    n = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (eoc_o) n++;
    end
    chk("R7 no eoc", n, 0);
    chk("R7 result kept", result_o, 8'h3C);
    chk("R7 no irq", irq_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule